// File: doc/BRIEF.md
# Parallel Flash Word Program Sequencer

This block sits on the host side of a 16-bit parallel flash bus and writes a single word into the flash part. The user supplies a target address, a data word and a one-cycle start request. The block then drives the flash chip enable, output enable, write enable, address, write data and a drive-enable for the bidirectional data bus.

A program operation has two stages. First come three unlock writes and then the user write, four write-enable pulses in all. After that the block polls the programmed address with repeated reads until bit 6 of the returned data stops changing. When that happens the block pulses `done`. If the poll budget runs out first, it pulses `err`. Either way it returns to idle.

All bus phase lengths are given in nanoseconds as parameters. They are turned into whole clock cycles, rounded up, from the clock period parameter, so the minimum flash timings hold at any clock rate.

Top module: `flash_prog_seq`

## Requirements
- R1: An accepted start issues exactly four write pulses, in this order: address 16'h5555 with data 16'h00AA, then address 16'h2AAA with data 16'h0055, then address 16'h5555 with data 16'h00A0, then the user address with the user data.
- R2: Every write-enable low pulse lasts at least ceil(T_WP_NS/CLK_NS) cycles. Between two pulses of one operation, write enable stays high for at least ceil(T_WPH_NS/CLK_NS) cycles.
- R3: Output enable is high whenever write enable is low. The data-bus drive enable is low whenever output enable is low.
- R4: Address and write data are stable for the whole of each write-enable low pulse. The values present at the rising write edge are the values of that pulse's write.
- R5: Poll reads all use the user address. Between consecutive reads, output enable stays high for at least ceil(T_OEH_NS/CLK_NS) cycles. Read data is sampled after output enable has been low for ceil(T_OE_ACC_NS/CLK_NS) cycles.
- R6: The operation completes, with a `done` pulse, on the first read whose bit 6 equals bit 6 of the previous read. This includes a match on read number MAX_POLLS.
- R7: If MAX_POLLS reads pass without such a match, `err` pulses after the last read and no further read is made.
- R8: `done` and `err` are one-cycle pulses and are never high together. In the pulse cycle `busy` is low and chip enable is high.
- R9: `start` is accepted only when `busy` is low. A start while busy has no effect on the bus sequence, and a start in the `done` cycle begins a new operation.
- R10: After reset, chip enable, output enable and write enable are high, and `busy`, `done`, `err` and the data drive enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to program a word |
| user_addr | input | 16 | Word address to program |
| user_data | input | 16 | Word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: programming finished |
| err | output | 1 | One-cycle pulse: poll budget exhausted |
| fl_addr | output | 16 | Flash address bus |
| fl_wdata | output | 16 | Data driven onto the flash data bus |
| fl_dq_oe | output | 1 | Drive enable for the data bus (1 = host drives) |
| fl_rdata | input | 16 | Data read back from the flash data bus |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |

## Verification
Two outcomes can land on the same final poll read: a bit 6 match and the end of the poll budget. The bench sets up a toggling flash model whose first equal pair arrives on exactly read MAX_POLLS, which must give `done`, and a second case where that read still differs, which must give `err` with no extra read. The completion pulse and a fresh start can also share one cycle. The bench raises `start` in the `done` cycle and expects a full new operation to follow, while a start raised in mid-sequence must leave the write log of the running operation unchanged.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_LOW,
        ST_WR_HIGH,
        ST_POLL_RD,
        ST_POLL_GAP
    } seq_state_t;

    typedef struct packed {
        logic [15:0] addr;
        logic [15:0] data;
    } bus_word_t;

    localparam int WRITE_STEPS = 4;

    // ceiling of a time over the clock period, at least one cycle
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // address/data of each write step; the last step carries the user word
    function automatic bus_word_t step_word(input logic [1:0] idx, input bus_word_t user);
        bus_word_t w;
        case (idx)
            2'd0: w = '{addr: 16'h5555, data: 16'h00AA};
            2'd1: w = '{addr: 16'h2AAA, data: 16'h0055};
            2'd2: w = '{addr: 16'h5555, data: 16'h00A0};
            default: w = user;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fps_phase_timer.sv
module fps_phase_timer #(
    parameter int MAX_CYC = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [$clog2(MAX_CYC+1)-1:0] load_val,
    output logic                         expired
);
    localparam int CW = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/fps_toggle_eval.sv
module fps_toggle_eval #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic match,
    output logic at_limit
);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic          prev_bit;
    logic          have_prev;
    logic [PW-1:0] reads;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_bit  <= 1'b0;
            have_prev <= 1'b0;
            reads     <= '0;
        end else if (sample) begin
            prev_bit  <= bit_in;
            have_prev <= 1'b1;
            reads     <= reads + 1'b1;
        end
    end

    assign match    = have_prev && (bit_in == prev_bit);
    assign at_limit = (reads == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int CLK_NS       = 4,
    parameter int T_SETUP_NS   = 1,
    parameter int T_WP_NS      = 90,
    parameter int T_WPH_NS     = 90,
    parameter int T_OE_ACC_NS  = 50,
    parameter int T_OEH_NS     = 150,
    parameter int MAX_POLLS    = 1024,
    parameter int TOGGLE_BIT   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] user_addr,
    input  logic [15:0] user_data,
    output logic        busy,
    output logic        done,
    output logic        err,
    output logic [15:0] fl_addr,
    output logic [15:0] fl_wdata,
    output logic        fl_dq_oe,
    input  logic [15:0] fl_rdata,
    output logic        fl_ce_n,
    output logic        fl_oe_n,
    output logic        fl_we_n
);
    localparam int SETUP_C = ns_to_cycles(T_SETUP_NS, CLK_NS);
    localparam int WP_C    = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int WPH_C   = ns_to_cycles(T_WPH_NS, CLK_NS);
    localparam int ACC_C   = ns_to_cycles(T_OE_ACC_NS, CLK_NS);
    localparam int OEH_C   = ns_to_cycles(T_OEH_NS, CLK_NS);
    localparam int MAX_C   = (WP_C > OEH_C) ? WP_C : OEH_C;
    localparam int MAX_ALL = (MAX_C > WPH_C) ? ((MAX_C > ACC_C) ? MAX_C : ACC_C)
                                              : ((WPH_C > ACC_C) ? WPH_C : ACC_C);
    localparam int TW      = $clog2(MAX_ALL + 1);

    seq_state_t    state, state_nx;
    logic [1:0]    step, step_nx;
    bus_word_t     user_q;
    bus_word_t     cur_word;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          poll_clear, poll_sample, poll_match, poll_last;
    logic          done_nx, err_nx;

    fps_phase_timer #(.MAX_CYC(MAX_ALL)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    fps_toggle_eval #(.MAX_POLLS(MAX_POLLS)) u_eval (
        .clk      (clk),
        .rst      (rst),
        .clear    (poll_clear),
        .sample   (poll_sample),
        .bit_in   (fl_rdata[TOGGLE_BIT]),
        .match    (poll_match),
        .at_limit (poll_last)
    );

    always_comb begin
        state_nx    = state;
        step_nx     = step;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        poll_clear  = 1'b0;
        poll_sample = 1'b0;
        done_nx     = 1'b0;
        err_nx      = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                state_nx = ST_WR_SETUP;
                step_nx  = 2'd0;
                tmr_load = 1'b1;
                tmr_val  = TW'(SETUP_C - 1);
            end
            ST_WR_SETUP: if (tmr_exp) begin
                state_nx = ST_WR_LOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(WP_C - 1);
            end
            ST_WR_LOW: if (tmr_exp) begin
                state_nx = ST_WR_HIGH;
                tmr_load = 1'b1;
                tmr_val  = TW'(WPH_C - 1);
            end
            ST_WR_HIGH: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (step == 2'(WRITE_STEPS - 1)) begin
                    state_nx   = ST_POLL_RD;
                    tmr_val    = TW'(ACC_C - 1);
                    poll_clear = 1'b1;
                end else begin
                    state_nx = ST_WR_SETUP;
                    step_nx  = step + 2'd1;
                    tmr_val  = TW'(SETUP_C - 1);
                end
            end
            ST_POLL_RD: if (tmr_exp) begin
                poll_sample = 1'b1;
                if (poll_match) begin
                    state_nx = ST_IDLE;
                    done_nx  = 1'b1;
                end else if (poll_last) begin
                    state_nx = ST_IDLE;
                    err_nx   = 1'b1;
                end else begin
                    state_nx = ST_POLL_GAP;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(OEH_C - 1);
                end
            end
            ST_POLL_GAP: if (tmr_exp) begin
                state_nx = ST_POLL_RD;
                tmr_load = 1'b1;
                tmr_val  = TW'(ACC_C - 1);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            step   <= 2'd0;
            user_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            state <= state_nx;
            step  <= step_nx;
            done  <= done_nx;
            err   <= err_nx;
            if (state == ST_IDLE && start)
                user_q <= '{addr: user_addr, data: user_data};
        end
    end

    assign cur_word = step_word(step, user_q);
    logic in_write;
    assign in_write = (state == ST_WR_SETUP) || (state == ST_WR_LOW) || (state == ST_WR_HIGH);

    assign busy     = (state != ST_IDLE);
    assign fl_ce_n  = (state == ST_IDLE);
    assign fl_we_n  = (state != ST_WR_LOW);
    assign fl_oe_n  = (state != ST_POLL_RD);
    assign fl_dq_oe = in_write;
    assign fl_addr  = in_write ? cur_word.addr : user_q.addr;
    assign fl_wdata = in_write ? cur_word.data : 16'h0000;
endmodule

// File: rtl/flash_prog_seq_chk.sv
module flash_prog_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic [15:0] fl_addr,
    input logic [15:0] fl_wdata,
    input logic        fl_dq_oe,
    input logic        fl_ce_n,
    input logic        fl_oe_n,
    input logic        fl_we_n
);
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> fl_oe_n); // R3
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_dq_oe); // R3
    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_wdata))); // R4
    AST_POLL_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fl_oe_n && $past(!fl_oe_n)) |-> $stable(fl_addr)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err); // R8
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done && err)); // R8
    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (done || err) |-> (!busy && fl_ce_n)); // R8
endmodule

bind flash_prog_seq flash_prog_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .fl_addr  (fl_addr),
    .fl_wdata (fl_wdata),
    .fl_dq_oe (fl_dq_oe),
    .fl_ce_n  (fl_ce_n),
    .fl_oe_n  (fl_oe_n),
    .fl_we_n  (fl_we_n)
);

// File: tb/sim_flash_prog_seq.sv
module sim_flash_prog_seq;
    localparam int CLK_NS = 4;
    localparam int MAXP   = 8;
    localparam int WP_C   = 23;   // ceil(90/4)
    localparam int WPH_C  = 23;   // ceil(90/4)
    localparam int OEH_C  = 38;   // ceil(150/4)

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] user_addr = '0, user_data = '0;
    logic        busy, done, err, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
    logic [15:0] fl_addr, fl_wdata;
    logic [15:0] fl_rdata = '0;

    int checks = 0, errors = 0;

    always #(CLK_NS/2) clk = ~clk;

    flash_prog_seq #(.CLK_NS(CLK_NS), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst(rst), .start(start), .user_addr(user_addr), .user_data(user_data),
        .busy(busy), .done(done), .err(err), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_dq_oe(fl_dq_oe), .fl_rdata(fl_rdata), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
        .fl_we_n(fl_we_n)
    );

    // flash model and bus monitor state
    int          cur_b = 0;
    logic [15:0] cur_data = '0, exp_addr = '0;
    logic [15:0] log_a [8];
    logic [15:0] log_d [8];
    int nwr = 0, nrd = 0, lo_run = 0, hi_run = 0, gap_run = 0;
    int min_lo = 999, min_hi = 999, min_gap = 999, oe_viol = 0, addr_bad = 0, unstable = 0;
    logic        seen_rise = 1'b0, prev_we = 1'b1, prev_oe = 1'b1;
    logic [15:0] lo_a = '0, lo_d = '0;

    always @(negedge clk) begin
        if (!fl_we_n) begin
            if (!fl_oe_n) oe_viol++;
            if (prev_we) begin
                if (seen_rise && hi_run < min_hi) min_hi = hi_run;
                lo_a = fl_addr; lo_d = fl_wdata; lo_run = 1;
            end else lo_run++;
        end else begin
            if (!prev_we) begin
                if (lo_run < min_lo) min_lo = lo_run;
                if (fl_addr != lo_a || fl_wdata != lo_d) unstable++;
                if (nwr < 8) begin log_a[nwr] = fl_addr; log_d[nwr] = fl_wdata; end
                nwr++; hi_run = 1; seen_rise = 1'b1;
            end else hi_run++;
        end
        if (!fl_oe_n) begin
            if (prev_oe) begin
                if (nrd > 0 && gap_run < min_gap) min_gap = gap_run;
                if (fl_addr != exp_addr) addr_bad++;
                fl_rdata = cur_data;
                fl_rdata[6] = (nrd < cur_b) ? nrd[0] : cur_data[6];
                nrd++;
            end
        end else begin
            if (!prev_oe) gap_run = 1; else gap_run++;
        end
        if (fl_ce_n) seen_rise = 1'b0;
        prev_we = fl_we_n; prev_oe = fl_oe_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected outcome from the toggle rule: first read equal to its predecessor
    task automatic predict(input int b, input bit d6, output bit is_err, output int reads);
        int n = 1;
        while (((n < b) ? n[0] : d6) != (((n - 1) < b) ? (n - 1) & 1 : d6)) n++;
        reads = n + 1;
        is_err = 1'b0;
        if (reads > MAXP) begin is_err = 1'b1; reads = MAXP; end
    endtask

    task automatic arm(input logic [15:0] a, input logic [15:0] d, input int b);
        cur_b = b; cur_data = d; exp_addr = a;
        nwr = 0; nrd = 0; min_lo = 999; min_hi = 999; min_gap = 999;
        oe_viol = 0; addr_bad = 0; unstable = 0;
        user_addr = a; user_data = d; start = 1'b1;
    endtask

    task automatic wait_end(output bit got_done, output bit got_err);
        int guard = 0;
        @(negedge clk); start = 1'b0;
        while (!(done || err) && guard < 5000) begin @(negedge clk); guard++; end
        got_done = done; got_err = err;
    endtask

    task automatic check_op(input logic [15:0] a, input logic [15:0] d, input bit gd, input bit ge);
        bit xe; int xr;
        predict(cur_b, d[6], xe, xr);
        chk(nwr == 4, "R1 write count", nwr, 4);
        if (nwr >= 4) begin
            chk(log_a[0] == 16'h5555 && log_d[0] == 16'h00AA, "R1 step0", int'(log_d[0]), 'hAA);
            chk(log_a[1] == 16'h2AAA && log_d[1] == 16'h0055, "R1 step1", int'(log_d[1]), 'h55);
            chk(log_a[2] == 16'h5555 && log_d[2] == 16'h00A0, "R1 step2", int'(log_d[2]), 'hA0);
            chk(log_a[3] == a && log_d[3] == d, "R1 user word", int'(log_a[3]), int'(a));
        end
        chk(min_lo >= WP_C, "R2 we low width", min_lo, WP_C);
        chk(min_hi >= WPH_C, "R2 we high width", min_hi, WPH_C);
        chk(oe_viol == 0, "R3 oe low in write", oe_viol, 0);
        chk(unstable == 0, "R4 write stability", unstable, 0);
        chk(addr_bad == 0, "R5 poll address", addr_bad, 0);
        if (nrd > 1) chk(min_gap >= OEH_C, "R5 oe gap", min_gap, OEH_C);
        chk(nrd == xr, xe ? "R7 read count" : "R6 read count", nrd, xr);
        chk(gd == !xe, "R6 done", gd, !xe);
        chk(ge == xe, "R7 err", ge, xe);
        chk(!busy && fl_ce_n, "R8 idle at pulse", busy, 0);
    endtask

    // {addr, data, busy reads}
    localparam logic [47:0] VEC [6] = '{
        {16'h0100, 16'h1234, 16'd0},
        {16'h7F00, 16'hBEEF, 16'd1},
        {16'hFFFF, 16'h0040, 16'd3},
        {16'h2000, 16'h1234, 16'd7},   // match on last allowed read
        {16'h0001, 16'hBEEF, 16'd7},   // last read still differs
        {16'h4321, 16'h8000, 16'd30}
    };

    initial begin
        #(200000 * CLK_NS);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit gd, ge;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(fl_ce_n && fl_oe_n && fl_we_n, "R10 strobes high", {fl_ce_n, fl_oe_n, fl_we_n}, 7);
        chk(!busy && !done && !err && !fl_dq_oe, "R10 status low", {busy, done, err, fl_dq_oe}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < 6; i++) begin
            arm(VEC[i][47:32], VEC[i][31:16], int'(VEC[i][15:0]));
            wait_end(gd, ge);
            check_op(VEC[i][47:32], VEC[i][31:16], gd, ge);
            @(negedge clk);
            chk(!done && !err, "R8 single-cycle pulse", {done, err}, 0);
            repeat (3) @(negedge clk);
        end

        // R9: start while busy is ignored
        arm(16'h0A0A, 16'h5A5A, 2);
        @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        user_addr = 16'h0B0B; user_data = 16'h0000; start = 1'b1;
        wait_end(gd, ge);
        chk(nwr == 4 && log_a[3] == 16'h0A0A && log_d[3] == 16'h5A5A,
            "R9 start while busy ignored", int'(log_a[3]), 'h0A0A);

        // R9: start in the done cycle starts a new operation
        arm(16'h3333, 16'h0011, 0);
        wait_end(gd, ge);
        chk(gd, "R9 first done", gd, 1);
        arm(16'h4444, 16'h0022, 1);
        @(negedge clk); start = 1'b0;
        chk(busy, "R9 accepted in done cycle", busy, 1);
        wait_end(gd, ge);
        check_op(16'h4444, 16'h0022, gd, ge);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule